// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counters. Each one is built from an 8-bit low count register and an 8-bit high count register. Software reaches every register through one address bus. A write takes effect on the next rising clock edge, and a read returns data combinationally. Each timer has a 4-bit configuration nibble that selects:

- an external gate qualifier;
- the count source: the system clock divided by 12, or falling edges on an external pin;
- one of four counting modes.

A run bit per timer starts and stops counting.

When a timer rolls over, it sets its overflow flag. The two flags go to an interrupt controller. That controller pulses the acknowledge input for a timer when it vectors to that timer's handler, and the acknowledge clears the flag. Software can also write the flags directly.

The four modes are:

- a 13-bit count, where the low five bits of the low register act as a prescaler below the high register;
- a 16-bit cascade;
- an 8-bit count with automatic reload from the high register;
- a split mode. Timer 0's low byte keeps timer 0's controls. Timer 0's high byte becomes a separate 8-bit timer, which is run by timer 1's run bit and raises timer 1's flag.

Top module: `tmr_pair_unit`

Register map, selected by `addr`:

| Address | Contents |
|---|---|
| 0 | configuration byte: timer 1 in the upper nibble, timer 0 in the lower nibble |
| 1 | run bits: bit0 is timer 0, bit1 is timer 1 |
| 2 | timer 0 low |
| 3 | timer 0 high |
| 4 | timer 1 low |
| 5 | timer 1 high |
| 6 | flags: bit0 is timer 0, bit1 is timer 1 |

Unused addresses read as zero.

## Requirements
- R1: After reset, every register at addresses 0 to 6 reads 0 and both `ovf_flag` bits are 0.
- R2: The divided-clock event first occurs on the 14th rising edge after `rst_n` rises, and then every 12 clocks. In mode 1 (mode bits 01), a running timer adds one to {high,low} per event. A carry rolls FFFF over to 0000 and sets that timer's flag.
- R3: In mode 0 (00), bits 4:0 of the low register count. A carry out of them increments the high register, and bits 7:5 of the low register keep their value. Rollover from high=FF with low[4:0]=1F sets the flag.
- R4: In mode 2 (10), only the low register counts. When it passes FF it loads the high register's value instead of 00 and sets the flag, and the high register is unchanged.
- R5: When timer 0 is in mode 3 (11), its low byte counts under timer 0's run, gate and source bits and sets flag 0. Its high byte counts divided-clock events whenever timer 1's run bit is 1, and its rollover sets flag 1. A timer 1 in mode 3 holds its count.
- R6: The configuration layout is bit3 gate, bit2 source, bits1:0 mode. With source bit 1, the timer counts falling edges of its count pin. The pin is sampled once per divided-clock event, so at most one count occurs per 12 clocks.
- R7: With the gate bit at 1, the timer counts only while its gate pin is high and its run bit is 1.
- R8: With its run bit at 0, a timer's count registers keep their value.
- R9: A software write to a count register in the same cycle as an increment stores the written value.
- R10: A pulse on `flag_ack[i]` clears flag i. A write to address 6 sets or clears the flags directly. The priority is software write, then hardware set, then acknowledge.
- R11: The configuration byte reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| ext_cnt_pin | input | 2 | Per-timer external count inputs |
| ext_gate_pin | input | 2 | Per-timer gate qualifier inputs |
| flag_ack | input | 2 | Per-timer interrupt-vector acknowledge |
| ovf_flag | output | 2 | Per-timer overflow flags |

## Verification
The embedded assertions check the following on every cycle:

- idle count registers hold still;
- the 16-bit wrap returns to zero;
- an 8-bit reload copies the high byte;
- a flag rises only from an overflow or a software write;
- an acknowledge with no competing set clears the flag.

Only the bench scenarios can show the rest:

- the exact tick phase after reset;
- the 13-bit prescaler carry, with the upper low-register bits left alone;
- the split-mode borrowing of timer 1's run bit and flag;
- pin-edge counting;
- gating;
- write-over-increment priority.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext_src;
    tmode_e mode;
  } tcfg_t;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_RUN  = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;
  localparam logic [2:0] A_FLAG = 3'd6;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic tick,
  output logic level,
  output logic fall_ev
);
  logic s1_q, s2_q, prev_q, prev_d;

  assign level   = s2_q;
  assign fall_ev = tick & prev_q & ~s2_q;

  always_comb begin
    prev_d = tick ? s2_q : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int PRE = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         split_en,
  input  tmode_e       mode,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf,
  output logic         split_ovf
);
  localparam logic [2*W-1:0] ONE2 = {{(2*W-1){1'b0}}, 1'b1};

  logic [W-1:0] lo_d, hi_d;

  always_comb begin
    lo_d      = lo;
    hi_d      = hi;
    ovf       = 1'b0;
    split_ovf = 1'b0;
    if (cnt_en) begin
      unique case (mode)
        MODE_13: begin
          lo_d[PRE-1:0] = lo[PRE-1:0] + 1'b1;
          if (&lo[PRE-1:0]) begin
            hi_d = hi + 1'b1;
            ovf  = &hi;
          end
        end
        MODE_16: begin
          {hi_d, lo_d} = {hi, lo} + ONE2;
          ovf          = &{hi, lo};
        end
        MODE_RELOAD: begin
          if (&lo) begin
            lo_d = hi;
            ovf  = 1'b1;
          end else begin
            lo_d = lo + 1'b1;
          end
        end
        MODE_SPLIT: begin
          lo_d = lo + 1'b1;
          ovf  = &lo;
        end
        default: ;
      endcase
    end
    if (split_en && mode == MODE_SPLIT) begin
      hi_d      = hi + 1'b1;
      split_ovf = &hi;
    end
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_d;
      hi <= hi_d;
    end
  end

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !split_en && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  // R2
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_16 && cnt_en && !wr_lo && !wr_hi && (&{hi, lo})) |=> ({hi, lo} == '0));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && cnt_en && !wr_lo && (&lo)) |=> (lo == $past(hi)));
endmodule

// File: rtl/tmr_pair_unit.sv
`timescale 1ns/1ps
module tmr_pair_unit
  import tmr_pkg::*;
#(
  parameter int W   = 8,
  parameter int PRE = 5,
  parameter int DIV = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   ext_cnt_pin,
  input  logic [1:0]   ext_gate_pin,
  input  logic [1:0]   flag_ack,
  output logic [1:0]   ovf_flag
);
  localparam int NT = 2;

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  tcfg_t [NT-1:0] cfg_q, cfg_d;
  logic  [NT-1:0] run_q, run_d, flag_q, flag_d;
  logic  [NT-1:0] cnt_lvl, cnt_fall, gate_lvl;
  logic  [NT-1:0] cnt_en, split_en, ovf, split_ovf, flag_set;
  logic  [NT-1:0] wr_lo, wr_hi;
  logic  [W-1:0]  lo [NT];
  logic  [W-1:0]  hi [NT];
  logic           tick, flag_wr;

  tmr_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_i_n), .tick(tick));

  assign flag_wr = wr_en && (addr == A_FLAG);
  assign wr_lo[0] = wr_en && (addr == A_LO0);
  assign wr_hi[0] = wr_en && (addr == A_HI0);
  assign wr_lo[1] = wr_en && (addr == A_LO1);
  assign wr_hi[1] = wr_en && (addr == A_HI1);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tmr_pin_sync u_cnt_sync (
      .clk(clk), .rst_n(rst_i_n), .pin(ext_cnt_pin[i]), .tick(tick),
      .level(cnt_lvl[i]), .fall_ev(cnt_fall[i])
    );
    tmr_pin_sync u_gate_sync (
      .clk(clk), .rst_n(rst_i_n), .pin(ext_gate_pin[i]), .tick(tick),
      .level(gate_lvl[i]), .fall_ev()
    );
    tmr_core #(.W(W), .PRE(PRE)) u_core (
      .clk(clk), .rst_n(rst_i_n),
      .cnt_en(cnt_en[i]), .split_en(split_en[i]), .mode(cfg_q[i].mode),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wr_data(wr_data),
      .lo(lo[i]), .hi(hi[i]), .ovf(ovf[i]), .split_ovf(split_ovf[i])
    );
  end

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      cnt_en[i] = (cfg_q[i].ext_src ? cnt_fall[i] : tick)
                  && run_q[i] && (!cfg_q[i].gate || gate_lvl[i]);
    end
    if (cfg_q[1].mode == MODE_SPLIT) cnt_en[1] = 1'b0;
    split_en[0] = tick && run_q[1];
    split_en[1] = 1'b0;
    flag_set[0] = ovf[0];
    flag_set[1] = ovf[1] | split_ovf[0];
  end

  always_comb begin
    cfg_d = cfg_q;
    run_d = run_q;
    if (wr_en && addr == A_CFG) begin
      cfg_d[0] = tcfg_t'(wr_data[3:0]);
      cfg_d[1] = tcfg_t'(wr_data[7:4]);
    end
    if (wr_en && addr == A_RUN) run_d = wr_data[1:0];
    for (int i = 0; i < NT; i++) begin
      if (flag_wr)          flag_d[i] = wr_data[i];
      else if (flag_set[i]) flag_d[i] = 1'b1;
      else if (flag_ack[i]) flag_d[i] = 1'b0;
      else                  flag_d[i] = flag_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign ovf_flag = flag_q;

  always_comb begin
    unique case (addr)
      A_CFG:   rd_data = W'({cfg_q[1], cfg_q[0]});
      A_RUN:   rd_data = {{(W-NT){1'b0}}, run_q};
      A_LO0:   rd_data = lo[0];
      A_HI0:   rd_data = hi[0];
      A_LO1:   rd_data = lo[1];
      A_HI1:   rd_data = hi[1];
      A_FLAG:  rd_data = {{(W-NT){1'b0}}, flag_q};
      default: rd_data = '0;
    endcase
  end

  // R10
  flag0_rise_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ovf_flag[0]) |-> $past(ovf[0] || flag_wr));

  // R5
  flag1_rise_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ovf_flag[1]) |-> $past(ovf[1] || split_ovf[0] || flag_wr));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flag_ack[0] && !flag_set[0] && !flag_wr) |=> !ovf_flag[0]);
endmodule

// File: tb/tmr_pair_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_pair_unit_tb_top;
  localparam int DIVB = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic [1:0] ext_cnt_pin = 2'b11;
  logic [1:0] ext_gate_pin = 2'b11;
  logic [1:0] flag_ack = 2'b00;
  logic [1:0] ovf_flag;

  int edge_n = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_port;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t exp_q[$];
  event  mon_ev;

  always #10 clk = ~clk;

  tmr_pair_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_cnt_pin(ext_cnt_pin), .ext_gate_pin(ext_gate_pin),
    .flag_ack(flag_ack), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = exp_q.pop_front();
        act = it.is_port ? {6'b0, ovf_flag} : rd_data;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string r);
    item_t it;
    addr = a;
    it.is_port = 1'b0; it.exp = e; it.req = r;
    exp_q.push_back(it);
    -> mon_ev;
    #3;
  endtask

  task automatic chk_flags(input logic [1:0] e, input string r);
    item_t it;
    it.is_port = 1'b1; it.exp = {6'b0, e}; it.req = r;
    exp_q.push_back(it);
    -> mon_ev;
    #3;
  endtask

  task automatic align();
    while (edge_n % DIVB != 2) step();
  endtask

  task automatic run_for(input logic [1:0] runs, input int n);
    align();
    wr(3'd1, {6'b0, runs});
    repeat (DIVB * n - 1) step();
    wr(3'd1, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    // R1 reset state
    for (int a = 0; a < 7; a++) chk_rd(3'(a), 8'h00, "R1 reset register");
    chk_flags(2'b00, "R1 reset flags");

    // R11 / R2: timer 0 in 16-bit mode across rollover
    wr(3'd0, 8'h01);
    chk_rd(3'd0, 8'h01, "R11 config readback");
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'hFF);
    run_for(2'b01, 3);
    chk_rd(3'd2, 8'h01, "R2 low after wrap");
    chk_rd(3'd3, 8'h00, "R2 high after wrap");
    chk_flags(2'b01, "R2 flag0 set on rollover");
    chk_rd(3'd4, 8'h00, "R8 idle timer1 low");
    // R8 stopped timer holds
    repeat (30) step();
    chk_rd(3'd2, 8'h01, "R8 stopped count holds");
    // R10 acknowledge clears
    flag_ack = 2'b01; step(); flag_ack = 2'b00;
    chk_flags(2'b00, "R10 ack clears flag0");

    // R3: timer 1 13-bit mode
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hFE);
    wr(3'd5, 8'hFF);
    run_for(2'b10, 3);
    chk_rd(3'd4, 8'hE1, "R3 prescaler bits and upper bits kept");
    chk_rd(3'd5, 8'h00, "R3 high after carry");
    chk_flags(2'b10, "R3 flag1 set");
    wr(3'd6, 8'h00);
    chk_flags(2'b00, "R10 software clear");

    // R4: reload mode
    wr(3'd0, 8'h02);
    wr(3'd3, 8'hF0);
    wr(3'd2, 8'hFE);
    run_for(2'b01, 4);
    chk_rd(3'd2, 8'hF2, "R4 low after reload");
    chk_rd(3'd3, 8'hF0, "R4 high unchanged");
    chk_flags(2'b01, "R4 flag0 set");
    wr(3'd6, 8'h00);

    // R5: split mode
    wr(3'd0, 8'h33);
    wr(3'd2, 8'h10);
    wr(3'd3, 8'hFE);
    wr(3'd4, 8'h55);
    wr(3'd5, 8'h66);
    run_for(2'b01, 2);
    chk_rd(3'd2, 8'h12, "R5 split low counts");
    chk_rd(3'd3, 8'hFE, "R5 split high idle without run1");
    run_for(2'b10, 3);
    chk_rd(3'd3, 8'h01, "R5 split high counts on run1");
    chk_rd(3'd2, 8'h12, "R5 split low held");
    chk_rd(3'd4, 8'h55, "R5 timer1 low stopped");
    chk_rd(3'd5, 8'h66, "R5 timer1 high stopped");
    chk_flags(2'b10, "R5 high byte sets flag1");
    wr(3'd6, 8'h00);

    // R6: external falling edges
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    align();
    wr(3'd1, 8'h01);
    for (int k = 1; k <= 8; k++) begin
      ext_cnt_pin[0] = (k % 2 == 0);
      repeat ((k == 1) ? DIVB - 1 : DIVB) step();
    end
    wr(3'd1, 8'h00);
    ext_cnt_pin[0] = 1'b1;
    chk_rd(3'd2, 8'h04, "R6 counts pin falling edges");

    // R7: gate
    wr(3'd0, 8'h09);
    wr(3'd2, 8'h00);
    ext_gate_pin[0] = 1'b0;
    repeat (4) step();
    run_for(2'b01, 3);
    chk_rd(3'd2, 8'h00, "R7 gate low blocks count");
    ext_gate_pin[0] = 1'b1;
    repeat (4) step();
    run_for(2'b01, 3);
    chk_rd(3'd2, 8'h03, "R7 gate high allows count");

    // R9: write coinciding with increment
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h00);
    align();
    wr(3'd1, 8'h01);
    repeat (DIVB - 2) step();
    wr(3'd2, 8'h40);
    wr(3'd1, 8'h00);
    chk_rd(3'd2, 8'h40, "R9 write wins over increment");

    // R10 software set
    wr(3'd6, 8'h01);
    chk_flags(2'b01, "R10 software set flag0");
    chk_rd(3'd6, 8'h01, "R10 flag register readback");

    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule